// File: doc/BRIEF.md
# Integer ALU with Shifts

A purely combinational 32-bit integer arithmetic and logic unit for a simple load/store processor datapath. Each cycle the execute stage presents two operands, a 5-bit shift amount, a 16-bit upper-immediate value and a 3-bit operation code. The block returns a full-width result and a separate equality flag that branch resolution uses to decide a taken or not-taken outcome.

The operations are add, subtract, bitwise OR, signed set-less-than, logical left shift, logical right shift and load-upper-immediate. Add-immediate is handled by the surrounding datapath, which places the extended immediate on operand B and selects add. Arithmetic wraps modulo 2^32 and never raises an exception. The unit holds no state and has no handshake: the result is valid in the same cycle as its inputs, so there is no back-pressure to manage.

Top module: `int_alu`

## Requirements
- R1: With op code 0 (add), result equals (A + B) mod 2^32; a carry out of bit 31 is dropped without any other effect.
- R2: With op code 1 (subtract), result equals (A - B) mod 2^32, wrapping silently.
- R3: With op code 2 (or), result is the bitwise OR of A and B.
- R4: With op code 3 (set-less-than), result is exactly 32'h0000_0001 when A is less than B as signed two's complement numbers and 32'h0000_0000 otherwise, including when A equals B.
- R5: With op code 4 (shift left), result is operand B shifted left by the shift-amount input (0 to 31) with zeros entering at bit 0; operand A has no effect.
- R6: With op code 5 (shift right), result is operand B shifted right by the shift-amount input with zeros entering at bit 31; operand A has no effect.
- R7: With op code 6 (load upper), result bits 31..16 equal the upper-immediate input and bits 15..0 are zero, whatever A, B and the shift amount hold.
- R8: The equality flag is 1 exactly when A equals B, for every op code.
- R9: Op code 7 is unassigned and gives a result of zero.
- R10: The shift-amount input has no effect on the result for op codes other than 4 and 5, and the upper-immediate input has no effect on op codes other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 or, 3 set-less-than, 4 shift left, 5 shift right, 6 load upper, 7 unassigned |
| opnd_a | input | 32 | First operand (source register value) |
| opnd_b | input | 32 | Second operand, or the value to shift |
| shamt | input | 5 | Shift distance for the two shift operations |
| upper_imm | input | 16 | Immediate placed in the high half by load upper |
| result | output | 32 | Operation result |
| equal | output | 1 | High when opnd_a equals opnd_b |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath, a 5-bit shift field and a 16-bit immediate. At that width the sign boundary at 0x8000_0000 against 0x7FFF_FFFF, the add carry out of bit 31, and shift distances of 0, 1 and 31 are all directly reachable, so signed compare and zero fill are exercised at their extremes. The immediate path is checked with the high-half placement followed by an add of a low-half constant, as the datapath does for a full 32-bit constant.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_OR   = 3'd2,
    OP_SLT  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_LUP  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
  end

  // R1 / R2: the wrapped sum or difference inverts back to operand A
  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      p_wrap_inverse_r1: assert (sub || (sum - b) == a)
        else $error("R1 add result does not invert");
      p_wrap_inverse_r2: assert (!sub || (sum + b) == a)
        else $error("R2 subtract result does not invert");
    end
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] diff,
  output logic             less,
  output logic             same
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    same = (a == b);
    // Signs differ: the negative one is smaller; otherwise the difference sign decides
    less = (a[MSB] != b[MSB]) ? a[MSB] : diff[MSB];
  end

  // R4: sign-split decision agrees with a signed compare; R8 equality excludes less
  always_comb begin
    if (!$isunknown({a, b, diff}) && diff == a - b) begin
      p_signed_less_r4: assert (less == ($signed(a) < $signed(b)))
        else $error("R4 signed compare mismatch");
      p_eq_not_less_r8: assert (!(same && less))
        else $error("R8 equal and less both set");
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  parameter bit LEFT  = 1'b1,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SH_W-1:0]  amount,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [0:SH_W];

  assign stage[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int DIST = 1 << i;
    if (LEFT) begin : g_left
      assign stage[i+1] = amount[i] ? {stage[i][WIDTH-1-DIST:0], {DIST{1'b0}}} : stage[i];
    end else begin : g_right
      assign stage[i+1] = amount[i] ? {{DIST{1'b0}}, stage[i][WIDTH-1:DIST]} : stage[i];
    end
  end

  assign dout = stage[SH_W];

  // R5 / R6: vacated positions are zero-filled
  always_comb begin
    if (!$isunknown({din, amount})) begin
      if (LEFT) begin
        p_zero_fill_r5: assert ((dout & ((WIDTH'(1) << amount) - WIDTH'(1))) == '0)
          else $error("R5 left shift did not zero fill");
      end else begin
        p_zero_fill_r6: assert ((dout & ~({WIDTH{1'b1}} >> amount)) == '0)
          else $error("R6 right shift did not zero fill");
      end
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int LOW_W = DATA_W - IMM_W
) (
  input  logic [alu_pkg::OP_W-1:0] op_sel,
  input  logic [DATA_W-1:0]        opnd_a,
  input  logic [DATA_W-1:0]        opnd_b,
  input  logic [SH_W-1:0]          shamt,
  input  logic [IMM_W-1:0]         upper_imm,
  output logic [DATA_W-1:0]        result,
  output logic                     equal
);
  import alu_pkg::*;

  alu_op_e          op;
  logic             do_sub;
  logic [DATA_W-1:0] arith;
  logic [DATA_W-1:0] shl_val;
  logic [DATA_W-1:0] shr_val;
  logic             lt;

  assign op     = alu_op_e'(op_sel);
  assign do_sub = (op == OP_SUB) || (op == OP_SLT);

  alu_addsub #(.WIDTH(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(do_sub), .sum(arith)
  );

  alu_compare #(.WIDTH(DATA_W)) u_cmp (
    .a(opnd_a), .b(opnd_b), .diff(arith), .less(lt), .same(equal)
  );

  alu_shifter #(.WIDTH(DATA_W), .LEFT(1'b1)) u_shl (
    .din(opnd_b), .amount(shamt), .dout(shl_val)
  );

  alu_shifter #(.WIDTH(DATA_W), .LEFT(1'b0)) u_shr (
    .din(opnd_b), .amount(shamt), .dout(shr_val)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = arith;
      OP_OR:          result = opnd_a | opnd_b;
      OP_SLT:         result = {{(DATA_W-1){1'b0}}, lt};
      OP_SHL:         result = shl_val;
      OP_SHR:         result = shr_val;
      OP_LUP:         result = {upper_imm, {LOW_W{1'b0}}};
      default:        result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b, shamt, upper_imm})) begin
      p_slt_range_r4: assert (op != OP_SLT || result[DATA_W-1:1] == '0)
        else $error("R4 set-less-than wider than one bit");
      p_upper_place_r7: assert (op != OP_LUP ||
                                (result[DATA_W-1:LOW_W] == upper_imm && result[LOW_W-1:0] == '0))
        else $error("R7 upper immediate misplaced");
      p_eq_flag_r8: assert (!(op == OP_SUB && equal) || result == '0)
        else $error("R8 equal flag with nonzero difference");
      p_unassigned_r9: assert (op != OP_NONE || result == '0)
        else $error("R9 unassigned op not zero");
    end
  end
endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
  logic        clk = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [15:0] upper_imm = '0;
  logic [31:0] result;
  logic        equal;
  int checks = 0, failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  int_alu dut (.op_sel, .opnd_a, .opnd_b, .shamt, .upper_imm, .result, .equal);

  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic [15:0] imm);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; upper_imm = imm;
    @(negedge clk);
  endtask

  task automatic check_res(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s result actual=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic exp);
    checks++;
    if (equal !== exp) begin
      failures++;
      $display("FAIL %s equal actual=%b expected=%b", req, equal, exp);
    end
  endtask

  task automatic t_idle();
    apply(3'd0, 32'h0, 32'h0, 5'd0, 16'h0);
    check_res("R1", 32'h0); check_eq("R8", 1'b1);
  endtask

  task automatic t_add_r1();
    apply(3'd0, 32'h1234_5678, 32'h1111_1111, 5'd0, 16'h0);
    check_res("R1", 32'h2345_6789);
    apply(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 16'h0);
    check_res("R1", 32'h0);
    apply(3'd0, 32'h02AC_0000, 32'h0000_0900, 5'd0, 16'h0);
    check_res("R1", 32'h02AC_0900);
  endtask

  task automatic t_sub_r2();
    apply(3'd1, 32'd5, 32'd7, 5'd0, 16'h0);
    check_res("R2", 32'hFFFF_FFFE);
    apply(3'd1, 32'h8000_0000, 32'd1, 5'd0, 16'h0);
    check_res("R2", 32'h7FFF_FFFF);
  endtask

  task automatic t_or_r3();
    apply(3'd2, 32'hF0F0_0000, 32'h0F00_00FF, 5'd0, 16'h0);
    check_res("R3", 32'hFFF0_00FF);
  endtask

  task automatic t_slt_r4();
    apply(3'd3, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'h0);
    check_res("R4", 32'd1);
    apply(3'd3, 32'd1, 32'hFFFF_FFFF, 5'd0, 16'h0);
    check_res("R4", 32'd0);
    apply(3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0);
    check_res("R4", 32'd1);
    apply(3'd3, 32'd9, 32'd9, 5'd0, 16'h0);
    check_res("R4", 32'd0);
    apply(3'd3, 32'd3, 32'd10, 5'd0, 16'h0);
    check_res("R4", 32'd1);
  endtask

  task automatic t_shl_r5();
    apply(3'd4, 32'hDEAD_BEEF, 32'hE000_000F, 5'd2, 16'h0);
    check_res("R5", 32'h8000_003C);
    apply(3'd4, 32'h0, 32'h0000_0003, 5'd31, 16'h0);
    check_res("R5", 32'h8000_0000);
    apply(3'd4, 32'h0, 32'hA5A5_A5A5, 5'd0, 16'h0);
    check_res("R5", 32'hA5A5_A5A5);
  endtask

  task automatic t_shr_r6();
    apply(3'd5, 32'h1234_0000, 32'hE000_000F, 5'd1, 16'h0);
    check_res("R6", 32'h7000_0007);
    apply(3'd5, 32'h0, 32'h8000_0000, 5'd31, 16'h0);
    check_res("R6", 32'h0000_0001);
    apply(3'd5, 32'h0, 32'hFFFF_FFFF, 5'd16, 16'h0);
    check_res("R6", 32'h0000_FFFF);
  endtask

  task automatic t_lui_r7();
    apply(3'd6, 32'hABCD_1234, 32'hFFFF_FFFF, 5'd7, 16'h02AC);
    check_res("R7", 32'h02AC_0000);
    apply(3'd6, 32'h0, 32'h0, 5'd0, 16'hFFFF);
    check_res("R7", 32'hFFFF_0000);
  endtask

  task automatic t_eq_r8();
    for (int k = 0; k < 8; k++) begin
      apply(3'(k), 32'h5555_AAAA, 32'h5555_AAAA, 5'd3, 16'h1);
      check_eq("R8", 1'b1);
      apply(3'(k), 32'h5555_AAAA, 32'h5555_AAAB, 5'd3, 16'h1);
      check_eq("R8", 1'b0);
    end
  endtask

  task automatic t_none_r9();
    apply(3'd7, 32'hFFFF_FFFF, 32'h1234_5678, 5'd4, 16'hBEEF);
    check_res("R9", 32'h0);
  endtask

  task automatic t_ignore_r10();
    apply(3'd0, 32'd100, 32'd44, 5'd31, 16'hFFFF);
    check_res("R10", 32'd144);
    apply(3'd2, 32'h0000_0F00, 32'h0000_00F0, 5'd9, 16'hA5A5);
    check_res("R10", 32'h0000_0FF0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_add_r1();
    t_sub_r2();
    t_or_r3();
    t_slt_r4();
    t_shl_r5();
    t_shr_r6();
    t_lui_r7();
    t_eq_r8();
    t_none_r9();
    t_ignore_r10();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule